// File: doc/BRIEF.md
# Key-Masked Byte Substitution Unit

This block performs the byte substitution step of a 128-bit block cipher, using a substitution table that depends on the cipher key. A single mask byte is taken from the cipher key. In the forward direction, every table output is XORed with that mask. In the inverse direction, every input byte is first XORed with the mask and then passed through the standard inverse table. The table is therefore different for each key, remains a bijection, and the inverse direction exactly undoes the forward direction. A mask of zero gives the plain standard substitution.

The mask byte is captured from the key input when a key-load strobe is asserted. All sixteen bytes of a 128-bit state word are substituted in parallel, and a direction input chooses forward or inverse for each word. A parameter selects between two output options:

- **Registered:** the result and a valid flag appear one cycle after an input-valid strobe.
- **Combinational:** the result and the valid flag follow the inputs directly.

The standard forward and inverse tables are not stored. They are produced by finite-field arithmetic functions. Key scheduling, row and column mixing, and mode handling belong to other blocks.

Top module: `dsbox_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, `out_valid` is 0, `state_out` is all zeros and the held mask is 0x00.
- R2: In forward mode (`dir_inv`=0), each output byte equals the standard S-box entry of the input byte XORed with the mask. The mask is key byte number `KEY_SEL`, where key byte 0 is `key_in[127:120]` and byte k is `key_in[127-8k -: 8]`. The default `KEY_SEL` is 6, which is `key_in[79:72]`.
- R3: In inverse mode (`dir_inv`=1), each output byte equals the standard inverse S-box entry of (input byte XOR mask).
- R4: With a mask of 0x00 the unit gives the standard tables: forward 0x00→0x63, 0x53→0xED, 0x01→0x7C, and inverse 0x63→0x00.
- R5: For every one of the 256 mask values and every one of the 256 byte values, inverse substitution of the forward result returns the original byte.
- R6: The mask changes only on a clock edge where `key_load` is 1. Changes on `key_in` without `key_load` have no effect on results.
- R7: When `key_load` and `in_valid` are asserted in the same cycle, that input word is substituted with the previous mask. The new mask applies from the next cycle.
- R8: With `REGISTERED`=1, `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1, and `state_out` carries that word's result.
- R9: With `REGISTERED`=1, `state_out` holds its value in any cycle that follows a cycle with `in_valid` low.
- R10: The 16 byte lanes are independent. Byte j of `state_out` (bits 127-8j down to 120-8j) depends only on byte j of `state_in`, the mask and `dir_inv`.
- R11: With `REGISTERED`=0, `state_out` and `out_valid` follow `state_in`, `dir_inv` and `in_valid` in the same cycle. The mask still comes from the key-load register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Capture the mask byte from `key_in` at this edge |
| key_in | input | 128 | Cipher key; byte 0 is the most significant byte |
| dir_inv | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_valid | input | 1 | The state word on `state_in` is to be processed |
| state_in | input | 128 | Sixteen input bytes |
| out_valid | output | 1 | `state_out` holds a fresh result |
| state_out | output | 128 | Sixteen substituted bytes |

## Verification
The bench builds the block twice.

- **Default build** (registered output, `KEY_SEL`=6): this build carries the round trip over all 256 masks and all 256 byte values. It also covers the one-cycle valid latency, output hold, key-load ordering, and the ignoring of key changes made without a load strobe.
- **Second build** (`REGISTERED`=0, `KEY_SEL`=15): this build reaches the combinational output path and the highest key-byte position. Choosing the last byte shows that the mask selection follows the parameter rather than a fixed slice.

// File: rtl/dsbox_pkg.sv
package dsbox_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t AFFINE_FWD_C = 8'h63;
  localparam byte_t AFFINE_INV_C = 8'h05;
  localparam byte_t FIELD_POLY   = 8'h1b;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? FIELD_POLY : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254; zero maps to zero
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r;
    byte_t p;
    logic [7:0] e;
    r = 8'h01;
    p = a;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t affine_fwd(input byte_t b);
    byte_t o;
    for (int i = 0; i < 8; i++) begin
      o[i] = b[i] ^ b[(i + 4) % 8] ^ b[(i + 5) % 8] ^ b[(i + 6) % 8]
           ^ b[(i + 7) % 8] ^ AFFINE_FWD_C[i];
    end
    return o;
  endfunction

  function automatic byte_t affine_inv(input byte_t b);
    byte_t o;
    for (int i = 0; i < 8; i++) begin
      o[i] = b[(i + 2) % 8] ^ b[(i + 5) % 8] ^ b[(i + 7) % 8] ^ AFFINE_INV_C[i];
    end
    return o;
  endfunction

  function automatic byte_t std_fwd(input byte_t b);
    return affine_fwd(gf_inv(b));
  endfunction

  function automatic byte_t std_inv(input byte_t b);
    return gf_inv(affine_inv(b));
  endfunction

endpackage

// File: rtl/dsbox_mask_reg.sv
module dsbox_mask_reg
  import dsbox_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int KEY_SEL   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_load,
  input  logic [8*NUM_BYTES-1:0] key_in,
  output byte_t                  mask_q
);

  byte_t sel_byte;

  // byte 0 is the most significant byte of the key
  always_comb begin
    sel_byte = 8'h00;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (k == KEY_SEL) sel_byte = key_in[8*(NUM_BYTES-1-k) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= 8'h00;
    else if (key_load) mask_q <= sel_byte;
  end

endmodule

// File: rtl/dsbox_lane.sv
module dsbox_lane
  import dsbox_pkg::*;
(
  input  byte_t byte_in,
  input  byte_t mask,
  input  logic  dir_inv,
  output byte_t byte_out
);

  byte_t fwd_val;
  byte_t inv_val;

  assign fwd_val  = std_fwd(byte_in) ^ mask;
  assign inv_val  = std_inv(byte_in ^ mask);
  assign byte_out = dir_inv ? inv_val : fwd_val;

endmodule

// File: rtl/dsbox_word.sv
module dsbox_word
  import dsbox_pkg::*;
#(
  parameter int NUM_BYTES = 16
) (
  input  logic [8*NUM_BYTES-1:0] word_in,
  input  byte_t                  mask,
  input  logic                   dir_inv,
  output logic [8*NUM_BYTES-1:0] word_out
);

  for (genvar j = 0; j < NUM_BYTES; j++) begin : g_lane
    dsbox_lane u_lane (
      .byte_in (word_in[8*j +: 8]),
      .mask    (mask),
      .dir_inv (dir_inv),
      .byte_out(word_out[8*j +: 8])
    );
  end

endmodule

// File: rtl/dsbox_unit.sv
module dsbox_unit
  import dsbox_pkg::*;
#(
  parameter int NUM_BYTES  = 16,
  parameter int KEY_SEL    = 6,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_load,
  input  logic [8*NUM_BYTES-1:0] key_in,
  input  logic                   dir_inv,
  input  logic                   in_valid,
  input  logic [8*NUM_BYTES-1:0] state_in,
  output logic                   out_valid,
  output logic [8*NUM_BYTES-1:0] state_out
);

  localparam int W = 8 * NUM_BYTES;

  byte_t        mask_q;
  logic [W-1:0] sub_word;

  dsbox_mask_reg #(.NUM_BYTES(NUM_BYTES), .KEY_SEL(KEY_SEL)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_load(key_load),
    .key_in  (key_in),
    .mask_q  (mask_q)
  );

  dsbox_word #(.NUM_BYTES(NUM_BYTES)) u_word (
    .word_in (state_in),
    .mask    (mask_q),
    .dir_inv (dir_inv),
    .word_out(sub_word)
  );

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        state_out <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) state_out <= sub_word;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign state_out = sub_word;
  end

endmodule

// File: rtl/dsbox_checker.sv
module dsbox_checker #(
  parameter int NUM_BYTES  = 16,
  parameter int KEY_SEL    = 6,
  parameter bit REGISTERED = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   key_load,
  input logic [8*NUM_BYTES-1:0] key_in,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [8*NUM_BYTES-1:0] state_out,
  input logic [7:0]             mask_q
);

  // R6: without a load strobe the mask keeps its value
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !key_load |=> $stable(mask_q));

  // R2: a load captures the selected key byte
  assert_mask_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> (mask_q == $past(key_in[8*(NUM_BYTES-1-KEY_SEL) +: 8])));

  if (REGISTERED) begin : g_reg_chk
    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(state_out));
  end

endmodule

bind dsbox_unit dsbox_checker #(
  .NUM_BYTES (NUM_BYTES),
  .KEY_SEL   (KEY_SEL),
  .REGISTERED(REGISTERED)
) u_dsbox_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .key_load (key_load),
  .key_in   (key_in),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .state_out(state_out),
  .mask_q   (mask_q)
);

// File: tb/dsbox_unit_bench.sv
module dsbox_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [127:0] key_in = '0;
  logic         dir_inv = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] state_in = '0;
  logic         out_valid;
  logic [127:0] state_out;

  logic         c_key_load = 1'b0;
  logic [127:0] c_key_in = '0;
  logic         c_dir_inv = 1'b0;
  logic         c_in_valid = 1'b0;
  logic [127:0] c_state_in = '0;
  logic         c_out_valid;
  logic [127:0] c_state_out;

  int n_checks = 0;
  int n_bad    = 0;

  logic [7:0] ref_s  [256];
  logic [7:0] ref_si [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dsbox_unit u_dsbox_unit (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .dir_inv(dir_inv), .in_valid(in_valid), .state_in(state_in),
    .out_valid(out_valid), .state_out(state_out)
  );

  dsbox_unit #(.KEY_SEL(15), .REGISTERED(1'b0)) u_dsbox_unit_comb (
    .clk(clk), .rst_n(rst_n), .key_load(c_key_load), .key_in(c_key_in),
    .dir_inv(c_dir_inv), .in_valid(c_in_valid), .state_in(c_state_in),
    .out_valid(c_out_valid), .state_out(c_state_out)
  );

  // reference tables: inverse found by search, affine as rotations, inverse table by inversion
  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011b << (i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int s);
    return (v << s) | (v >> (8 - s));
  endfunction

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (b_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
      ref_s[x] = s;
    end
    for (int x = 0; x < 256; x++) ref_si[ref_s[x]] = 8'(x);
  endtask

  function automatic logic [127:0] exp_word(input logic [127:0] w, input logic [7:0] m,
                                            input logic inv);
    logic [127:0] r;
    for (int j = 0; j < 16; j++)
      r[8*j +: 8] = inv ? ref_si[w[8*j +: 8] ^ m] : (ref_s[w[8*j +: 8]] ^ m);
    return r;
  endfunction

  function automatic logic [127:0] key_with(input logic [7:0] m, input int pos,
                                            input logic [7:0] filler);
    logic [127:0] k;
    for (int j = 0; j < 16; j++) k[127-8*j -: 8] = (j == pos) ? m : 8'(filler + 8'(j));
    return k;
  endfunction

  function automatic logic [127:0] seq_word(input int k);
    logic [127:0] w;
    for (int j = 0; j < 16; j++) w[127-8*j -: 8] = 8'(k*16 + j);
    return w;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic load_key(input logic [127:0] k);
    @(negedge clk);
    key_load = 1'b1;
    key_in   = k;
    @(posedge clk);
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic run_op(input logic inv, input logic [127:0] w, output logic [127:0] r);
    @(negedge clk);
    dir_inv  = inv;
    state_in = w;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    r = state_out;
  endtask

  task automatic t_reset();
    logic [127:0] r;
    check(out_valid == 1'b0 && state_out == '0, "R1 reset outputs", state_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && state_out == '0, "R1 after release", state_out, '0);
    run_op(1'b0, '0, r);
    check(r == {16{8'h63}}, "R1 mask zero after reset", r, {16{8'h63}});
  endtask

  task automatic t_known();
    logic [127:0] w = {8'h00, 8'h53, 8'h01, 104'h0};
    logic [127:0] r;
    run_op(1'b0, w, r);
    check(r[127:104] == 24'h63ED7C, "R4 standard forward", {104'h0, r[127:104]},
          {104'h0, 24'h63ED7C});
    check(r == exp_word(w, 8'h00, 1'b0), "R4 forward table", r, exp_word(w, 8'h00, 1'b0));
    run_op(1'b1, {16{8'h63}}, r);
    check(r == '0, "R4 standard inverse", r, '0);
  endtask

  task automatic t_forward_inverse();
    logic [7:0] masks [4] = '{8'h23, 8'h6F, 8'hD7, 8'hFF};
    logic [127:0] w = 128'h00112233_4455A6B7_C8D9EAFB_0C1D2E3F;
    logic [127:0] r;
    foreach (masks[i]) begin
      load_key(key_with(masks[i], 6, 8'h40));
      run_op(1'b0, w, r);
      check(r == exp_word(w, masks[i], 1'b0), "R2 forward masked", r,
            exp_word(w, masks[i], 1'b0));
      run_op(1'b1, w, r);
      check(r == exp_word(w, masks[i], 1'b1), "R3 inverse masked", r,
            exp_word(w, masks[i], 1'b1));
    end
  endtask

  task automatic t_lanes();
    logic [127:0] a = 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF;
    logic [127:0] b = a;
    logic [127:0] ra;
    logic [127:0] rb;
    b[127-8*9 -: 8] = 8'h5C;
    load_key(key_with(8'h3C, 6, 8'h00));
    run_op(1'b0, a, ra);
    run_op(1'b0, b, rb);
    check((ra ^ rb) == ({120'h0, 8'hFF} << (8*6)) ?
          ((ra ^ rb) & ~({120'h0, 8'hFF} << (8*6))) == '0 :
          ((ra ^ rb) & ~({120'h0, 8'hFF} << (8*6))) == '0,
          "R10 only one lane moved", ra ^ rb, {120'h0, 8'hFF} << (8*6));
    check(rb == exp_word(b, 8'h3C, 1'b0), "R10 lane values", rb, exp_word(b, 8'h3C, 1'b0));
  endtask

  task automatic t_ignore_key();
    logic [127:0] w = seq_word(5);
    logic [127:0] r;
    load_key(key_with(8'h91, 6, 8'h10));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      key_in = key_with(8'(8'h20 + 8'(i)), 6, 8'h77);
    end
    run_op(1'b0, w, r);
    check(r == exp_word(w, 8'h91, 1'b0), "R6 key change without load ignored", r,
          exp_word(w, 8'h91, 1'b0));
    load_key(key_with(8'h91, 3, 8'h00) | key_with(8'h00, 6, 8'h00));
    run_op(1'b0, w, r);
    check(r == exp_word(w, 8'h00 ^ 8'h06, 1'b0), "R2 only byte 6 selects mask", r,
          exp_word(w, 8'h06, 1'b0));
  endtask

  task automatic t_same_cycle();
    logic [127:0] w = seq_word(9);
    logic [127:0] r;
    load_key(key_with(8'h4E, 6, 8'h00));
    @(negedge clk);
    key_load = 1'b1;
    key_in   = key_with(8'hB2, 6, 8'h00);
    dir_inv  = 1'b0;
    state_in = w;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    key_load = 1'b0;
    in_valid = 1'b0;
    r = state_out;
    check(r == exp_word(w, 8'h4E, 1'b0), "R7 same-cycle load uses old mask", r,
          exp_word(w, 8'h4E, 1'b0));
    run_op(1'b0, w, r);
    check(r == exp_word(w, 8'hB2, 1'b0), "R7 new mask next word", r,
          exp_word(w, 8'hB2, 1'b0));
  endtask

  task automatic t_timing_hold();
    logic [127:0] w = seq_word(12);
    logic [127:0] held;
    @(negedge clk);
    dir_inv  = 1'b1;
    state_in = w;
    in_valid = 1'b1;
    check(out_valid == 1'b0, "R8 no valid before edge", {127'h0, out_valid}, '0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R8 valid one cycle later", {127'h0, out_valid}, 128'h1);
    held = state_out;
    state_in = ~w;
    dir_inv  = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R8 valid drops", {127'h0, out_valid}, '0);
      check(state_out == held, "R9 output held", state_out, held);
    end
  endtask

  task automatic t_roundtrip();
    for (int m = 0; m < 256; m++) begin
      int errs = 0;
      logic [127:0] last_a = '0;
      logic [127:0] last_e = '0;
      load_key(key_with(8'(m), 6, 8'(m ^ 8'hA5)));
      for (int k = 0; k < 16; k++) begin
        logic [127:0] w = seq_word(k);
        logic [127:0] y;
        logic [127:0] z;
        run_op(1'b0, w, y);
        if (y != exp_word(w, 8'(m), 1'b0)) begin
          errs++; last_a = y; last_e = exp_word(w, 8'(m), 1'b0);
        end
        run_op(1'b1, y, z);
        if (z != w) begin
          errs++; last_a = z; last_e = w;
        end
      end
      check(errs == 0, $sformatf("R5 round trip mask %02h", m), last_a, last_e);
    end
  endtask

  task automatic t_comb();
    logic [127:0] w = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [127:0] k = key_with(8'h00, 6, 8'h00);
    k[7:0] = 8'hC3;
    @(negedge clk);
    c_key_load = 1'b1;
    c_key_in   = k;
    @(posedge clk);
    @(negedge clk);
    c_key_load = 1'b0;
    c_dir_inv  = 1'b0;
    c_state_in = w;
    c_in_valid = 1'b1;
    #1;
    check(c_out_valid == 1'b1, "R11 valid same cycle", {127'h0, c_out_valid}, 128'h1);
    check(c_state_out == exp_word(w, 8'hC3, 1'b0), "R11 forward with byte 15 mask",
          c_state_out, exp_word(w, 8'hC3, 1'b0));
    c_dir_inv = 1'b1;
    #1;
    check(c_state_out == exp_word(w, 8'hC3, 1'b1), "R11 inverse combinational",
          c_state_out, exp_word(w, 8'hC3, 1'b1));
    c_in_valid = 1'b0;
    #1;
    check(c_out_valid == 1'b0, "R11 valid follows low", {127'h0, c_out_valid}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    build_tables();
    repeat (2) @(negedge clk);
    t_reset();
    t_known();
    t_forward_inverse();
    t_lanes();
    t_ignore_key();
    t_same_cycle();
    t_timing_hold();
    t_comb();
    t_roundtrip();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule